// File: doc/BRIEF.md
# Manchester II Frame Encoder

This block turns a serially supplied data word into one Manchester II coded frame for a differential serial bus. A frame opens with a sync pattern three bit periods long, carries a programmable number of data bits, and closes with a single parity bit. Two sync shapes are available: command sync and data sync. The parity sense can be even or odd. The block asks for each data bit in turn with a one-cycle shift clock, so the data source never has to present the whole word at once.

Everything runs on one encoder clock. A half-bit strobe, `half_tick`, stands in for the send clock at twice the bit rate. Each strobe moves the line by one half bit period. The line is driven on two complementary bipolar outputs, and an inhibit input forces both of them low. The block also divides the encoder clock by two and then by six, and brings the result out as a free-running clock.

Top module: `mfe_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, all state clears. After that edge `bip_one`, `bip_zero`, `shift_clk` and `div_clk` are all low.
- R2: The first six half bits of a frame are the sync. With `sync_cmd`=1 the line is high for three half bits and then low for three. With `sync_cmd`=0 it is low for three and then high for three.
- R3: Each data bit takes two half bits. A 1 is sent high then low and a 0 is sent low then high. Bits go out in the order they were fetched.
- R4: The two half bits after the data carry the parity bit, coded the same way as a data bit. With `par_odd`=1 the total number of ones in data plus parity is odd. With `par_odd`=0 it is even.
- R5: `word_len` sets N data bits. A value below 2 is treated as 2 and a value above 28 as 28, so a frame lasts 2*(N+4) half bits. `sync_cmd`, `par_odd` and `word_len` are latched when the frame starts, and changing them later in the frame has no effect.
- R6: Each frame raises `shift_clk` exactly N times, each time for one clock cycle. `ser_din` is captured on the clock edge that ends each pulse. The first pulse comes during the last sync half bit, and each later pulse comes in the second half of the bit before the one it feeds.
- R7: `enc_en` is looked at only on a half tick that finds no frame running, or on the tick that ends the last half bit of a frame. If it is high there, a new frame starts at once, so frames can run back to back. If it is low, the line goes idle with both outputs low. Changes to `enc_en` during a frame have no effect.
- R8: During a frame with `out_inhibit` low, exactly one of `bip_one`/`bip_zero` is high, and `bip_one` follows the line level. A high `out_inhibit` forces both outputs low in the same cycle and does not disturb the frame sequence.
- R9: `div_clk` starts low after reset and toggles every 6 encoder clocks, giving a period of 12 clocks.
- R10: The line level changes only in the clock cycle after an edge at which `half_tick` is high. Strobes are assumed to be at least 3 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| half_tick | input | 1 | One-cycle strobe per half bit period (twice the bit rate) |
| enc_en | input | 1 | Request to send a frame, sampled between frames |
| sync_cmd | input | 1 | 1 selects command sync, 0 selects data sync |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| word_len | input | 5 | Data bits per frame, clamped to 2..28 |
| ser_din | input | 1 | Serial data, captured at the edge ending a shift_clk pulse |
| out_inhibit | input | 1 | Forces both bipolar outputs low |
| shift_clk | output | 1 | One-cycle request for the next data bit |
| bip_one | output | 1 | High while the coded line is high |
| bip_zero | output | 1 | High while the coded line is low |
| div_clk | output | 1 | Encoder clock divided by 12 |

## Verification
The bench uses the default parameters: word lengths from 2 to 28, and a divider of 2 then 6. It sends a half tick every fourth clock, one clock more than the minimum the sequencer needs between strobes. That setting lets it reach the clamp at both ends of the length field, a 28-bit frame that fills the 6-bit half-bit counter up to 63, and a back-to-back restart on the final tick. It also covers select inputs changed in the middle of a frame and an inhibit window inside the data field. Every clock is compared against a queue of expected half-bit levels built when each frame starts.

// File: rtl/mfe_pkg.sv
// Shared constants and helpers for the Manchester frame encoder.
// Assumes: word length limits stay within 1..31 so a 5-bit field holds them.
package mfe_pkg;
    localparam int MFE_MIN_LEN = 2;
    localparam int MFE_MAX_LEN = 28;
    localparam int MFE_SYNC_HALVES = 6;

    // Clamp a requested word length into [lo, hi].
    function automatic logic [4:0] mfe_clamp(input logic [4:0] req,
                                             input logic [4:0] lo,
                                             input logic [4:0] hi);
        if (req < lo)      return lo;
        else if (req > hi) return hi;
        else               return req;
    endfunction
endpackage

// File: rtl/mfe_clk_div.sv
// Divides the encoder clock by PRE and then by POST. The output is a square
// wave that toggles every PRE*POST/2 clocks.
// Assumes: PRE*POST is even and at least 4.
module mfe_clk_div #(
    parameter int PRE  = 2,
    parameter int POST = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_o
);
    localparam int HALF = PRE * POST / 2;
    localparam int CW   = $clog2(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          div_q;

    // Count clocks and flip the output every HALF clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            div_q <= ~div_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign div_o = div_q;

    // R9
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != LAST) |=> $stable(div_q));
endmodule

// File: rtl/mfe_seq.sv
// Frame sequencer. It counts half bits, latches the frame settings at
// the start, requests serial data, accumulates parity and produces the
// registered line level.
// Assumes: half_tick is a one-cycle strobe with at least 3 clocks between
// strobes, so a data capture never meets a tick.
module mfe_seq #(
    parameter int MIN_LEN = mfe_pkg::MFE_MIN_LEN,
    parameter int MAX_LEN = mfe_pkg::MFE_MAX_LEN,
    parameter int LEN_W   = 5,
    parameter int H_W     = $clog2(2 * (MAX_LEN + 4))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_tick,
    input  logic             enc_en,
    input  logic             sync_cmd,
    input  logic             par_odd,
    input  logic [LEN_W-1:0] word_len,
    input  logic             ser_din,
    output logic             active_o,
    output logic             level_o,
    output logic             shift_o
);
    localparam logic [LEN_W-1:0] LMIN = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] LMAX = LEN_W'(MAX_LEN);
    localparam logic [H_W-1:0]   H3   = H_W'(3);
    localparam logic [H_W-1:0]   H5   = H_W'(5);
    localparam logic [H_W-1:0]   H6   = H_W'(mfe_pkg::MFE_SYNC_HALVES);

    logic             active_q, level_q, shift_q;
    logic             cmd_q, odd_q, par_q, cur_q;
    logic [LEN_W-1:0] len_q, len_in;
    logic [H_W-1:0]   h_q, h_nx, last_h, par_h, req_top;
    logic             start, nx_level;

    // Clamp the requested length and derive the frame landmarks.
    always_comb begin
        len_in  = LEN_W'(mfe_pkg::mfe_clamp(5'(word_len), 5'(LMIN), 5'(LMAX)));
        last_h  = H_W'(2 * len_q + 7);
        par_h   = H_W'(2 * len_q + 6);
        req_top = H_W'(2 * len_q + 3);
        h_nx    = h_q + 1'b1;
        start   = !active_q || (h_q == last_h);
    end

    // Line level for the next half bit: sync, then data, then parity.
    always_comb begin
        if (h_nx < H3)         nx_level = cmd_q;
        else if (h_nx < H6)    nx_level = ~cmd_q;
        else if (h_nx < par_h) nx_level = cur_q ^ h_nx[0];
        else                   nx_level = (par_q ^ odd_q) ^ h_nx[0];
    end

    // Sequence state: capture data, advance on half ticks, start or stop frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            level_q  <= 1'b0;
            shift_q  <= 1'b0;
            cmd_q    <= 1'b0;
            odd_q    <= 1'b0;
            par_q    <= 1'b0;
            cur_q    <= 1'b0;
            len_q    <= LMIN;
            h_q      <= '0;
        end else begin
            shift_q <= 1'b0;
            if (shift_q) begin
                cur_q <= ser_din;
                par_q <= par_q ^ ser_din;
            end
            if (half_tick) begin
                if (start) begin
                    h_q <= '0;
                    if (enc_en) begin
                        active_q <= 1'b1;
                        cmd_q    <= sync_cmd;
                        odd_q    <= par_odd;
                        len_q    <= len_in;
                        par_q    <= 1'b0;
                        level_q  <= sync_cmd;
                    end else begin
                        active_q <= 1'b0;
                        level_q  <= 1'b0;
                    end
                end else begin
                    h_q     <= h_nx;
                    level_q <= nx_level;
                    if (h_nx[0] && h_nx >= H5 && h_nx <= req_top)
                        shift_q <= 1'b1;
                end
            end
        end
    end

    assign active_o = active_q;
    assign level_o  = level_q;
    assign shift_o  = shift_q;

    // R6
    shift_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_q |=> !shift_q);
    // R10
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> $stable(h_q) && $stable(level_q));
    // R5
    frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (h_q <= last_h));
    // R7
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_tick && start && !enc_en) |=> (!active_o && !level_o));
endmodule

// File: rtl/mfe_line_drv.sv
// Bipolar output stage. It splits the line level into complementary one
// and zero outputs and forces both low when idle or inhibited.
// Assumes: level is low whenever the frame is not active.
module mfe_line_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic level,
    input  logic inhibit,
    output logic one_o,
    output logic zero_o
);
    // Gate the level onto the two rails.
    always_comb begin
        one_o  = active & level & ~inhibit;
        zero_o = active & ~level & ~inhibit;
    end

    // R8
    compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !inhibit) |-> (one_o ^ zero_o));
endmodule

// File: rtl/mfe_encoder.sv
// Manchester II frame encoder top. It joins the frame sequencer, the
// bipolar output stage and the encoder clock divider.
// Assumes: half_tick strobes come at twice the bit rate, at least 3 clocks apart.
module mfe_encoder #(
    parameter int MIN_LEN  = mfe_pkg::MFE_MIN_LEN,
    parameter int MAX_LEN  = mfe_pkg::MFE_MAX_LEN,
    parameter int DIV_PRE  = 2,
    parameter int DIV_POST = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_tick,
    input  logic       enc_en,
    input  logic       sync_cmd,
    input  logic       par_odd,
    input  logic [4:0] word_len,
    input  logic       ser_din,
    input  logic       out_inhibit,
    output logic       shift_clk,
    output logic       bip_one,
    output logic       bip_zero,
    output logic       div_clk
);
    logic act_w, lvl_w;

    mfe_seq #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LEN_W(5)) u_seq (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .enc_en(enc_en),
        .sync_cmd(sync_cmd), .par_odd(par_odd), .word_len(word_len),
        .ser_din(ser_din), .active_o(act_w), .level_o(lvl_w), .shift_o(shift_clk)
    );

    mfe_line_drv u_drv (
        .clk(clk), .rst_n(rst_n), .active(act_w), .level(lvl_w),
        .inhibit(out_inhibit), .one_o(bip_one), .zero_o(bip_zero)
    );

    mfe_clk_div #(.PRE(DIV_PRE), .POST(DIV_POST)) u_div (
        .clk(clk), .rst_n(rst_n), .div_o(div_clk)
    );
endmodule

// File: tb/mfe_encoder_test.sv
`timescale 1ns/1ps
// Self-checking bench. A queue-based model of expected half-bit levels is
// compared against the outputs on every clock.
module mfe_encoder_test;
    logic clk = 1'b0, rst_n = 1'b0, half_tick = 1'b0, enc_en = 1'b0;
    logic sync_cmd = 1'b0, par_odd = 1'b0, ser_din = 1'b0, out_inhibit = 1'b0;
    logic [4:0] word_len = 5'd2;
    logic shift_clk, bip_one, bip_zero, div_clk;

    mfe_encoder uut (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .enc_en(enc_en),
        .sync_cmd(sync_cmd), .par_odd(par_odd), .word_len(word_len),
        .ser_din(ser_din), .out_inhibit(out_inhibit), .shift_clk(shift_clk),
        .bip_one(bip_one), .bip_zero(bip_zero), .div_clk(div_clk)
    );

    always #10 clk = ~clk;

    int total = 0, bad = 0, divn = 0, frames = 0;
    int shifts = 0, halves = 0, m_len = 0;
    bit m_act = 0, m_lvl = 0, inh_seen = 0, done = 0;
    bit mq[$];
    bit feed[$];
    string tq[$];
    string m_tag = "R1";
    logic [27:0] cur_word = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Build the expected frame (R2 sync, R3 data, R4 parity, R5 clamp).
    task automatic build();
        int l;
        bit p;
        l = (word_len < 2) ? 2 : (word_len > 28) ? 28 : int'(word_len);
        m_len = l; p = par_odd;
        for (int i = 0; i < 3; i++) begin mq.push_back(sync_cmd);  tq.push_back("R2"); end
        for (int i = 0; i < 3; i++) begin mq.push_back(!sync_cmd); tq.push_back("R2"); end
        for (int k = 0; k < l; k++) begin
            mq.push_back(cur_word[k]);  tq.push_back("R3");
            mq.push_back(!cur_word[k]); tq.push_back("R3");
            p ^= cur_word[k];
            feed.push_back(cur_word[k]);
        end
        mq.push_back(p);  tq.push_back("R4");
        mq.push_back(!p); tq.push_back("R4");
        shifts = 0; halves = 0; inh_seen = 0;
    endtask

    // Model reaction to a half tick (R7 enable sampling between frames).
    task automatic m_tick();
        if (m_act && mq.size() == 0) begin
            chk(shifts == m_len, "R6", shifts, m_len);
            if (!inh_seen) chk(halves == 2 * (m_len + 4), "R5", halves, 2 * (m_len + 4));
            frames++;
        end
        if (mq.size() == 0) begin
            if (enc_en) build();
            else begin m_act = 0; m_lvl = 0; m_tag = "R7"; end
        end
        if (mq.size() > 0) begin
            m_lvl = mq.pop_front(); m_tag = tq.pop_front(); m_act = 1;
        end
    endtask

    // One clock: apply the tick, update the model, serve data, compare outputs (R10 timing).
    task automatic step(input bit tk);
        bit e1, e0;
        half_tick = tk;
        @(posedge clk);
        #2;
        if (!rst_n) begin
            m_act = 0; m_lvl = 0; mq.delete(); tq.delete(); feed.delete();
            divn = 0; m_tag = "R1";
        end else begin
            divn++;
            if (tk) m_tick();
        end
        if (m_act && out_inhibit) inh_seen = 1;
        if (shift_clk) begin
            shifts++;
            if (feed.size() == 0) chk(0, "R6", 1, 0);
            else ser_din = feed.pop_front();
        end
        e1 = m_act & m_lvl & !out_inhibit;
        e0 = m_act & !m_lvl & !out_inhibit;
        if (out_inhibit && m_act) begin
            chk(bip_one === 1'b0 && bip_zero === 1'b0, "R8", {bip_one, bip_zero}, 0);
        end else begin
            chk(bip_one === e1, m_tag, bip_one, e1);
            chk(bip_zero === e0, m_tag, bip_zero, e0);
        end
        chk(div_clk === 1'(divn / 6 % 2), "R9", div_clk, divn / 6 % 2);
        if (tk && rst_n && (bip_one | bip_zero)) halves++;
    endtask

    task automatic half();
        step(1); step(0); step(0); step(0);
    endtask

    // Send one frame. scr changes the selects mid-frame (R5 latching);
    // inh_at opens an inhibit window (R8).
    task automatic run_frame(input bit cmd, input bit odd, input logic [4:0] len,
                             input logic [27:0] w, input bit keep, input bit scr,
                             input int inh_at);
        int fdone;
        sync_cmd = cmd; par_odd = odd; word_len = len; cur_word = w; enc_en = 1;
        fdone = frames;
        half();
        if (!keep) enc_en = 0;
        if (scr) begin sync_cmd = !cmd; par_odd = !odd; word_len = 5'd3; end
        for (int i = 1; i < 200 && frames == fdone; i++) begin
            out_inhibit = (inh_at > 0 && i >= inh_at && i < inh_at + 5);
            half();
        end
        out_inhibit = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step(0);
        // R1 reset state
        chk(shift_clk === 1'b0 && bip_one === 1'b0 && bip_zero === 1'b0 && div_clk === 1'b0,
            "R1", {shift_clk, bip_one, bip_zero, div_clk}, 0);
        rst_n = 1;
        repeat (4) half();                                   // R7 idle stays low
        run_frame(1, 0, 5'd16, 28'h000A5C3, 0, 0, 0);        // command sync, even
        run_frame(0, 1, 5'd2, 28'h0000003, 0, 0, 0);         // minimum length, odd
        repeat (2) half();
        run_frame(0, 0, 5'd28, 28'h9E37B15, 0, 0, 0);        // maximum length
        run_frame(1, 1, 5'd0, 28'h0000002, 0, 0, 0);         // R5 clamp to 2
        run_frame(0, 1, 5'd31, 28'hFFFFFFF, 0, 0, 0);        // R5 clamp to 28
        run_frame(1, 0, 5'd7, 28'h0000055, 0, 1, 0);         // R5 latched selects
        run_frame(0, 0, 5'd10, 28'h00002C6, 0, 0, 9);        // R8 inhibit window
        run_frame(1, 1, 5'd5, 28'h0000013, 1, 0, 0);         // R7 back to back
        begin : second
            int f0;
            f0 = frames;
            enc_en = 0;
            for (int i = 0; i < 200 && frames == f0; i++) half();
            chk(frames == f0 + 1, "R7", frames, f0 + 1);
        end
        repeat (3) half();
        chk(shift_clk === 1'b0 && bip_one === 1'b0 && bip_zero === 1'b0, "R7",
            {shift_clk, bip_one, bip_zero}, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule